// File: doc/BRIEF.md
# BAR Address Window Decoder

This block turns the base address registers of a configuration header into live address windows and claims incoming transactions against them. It covers seven regions: six general base registers and one expansion ROM slot. For each region it works out whether the region is mapped, where the window starts, and where it ends. It then compares the address of an I/O or memory transaction with every mapped window and reports whether one was hit and which one.

The window arithmetic and the address compares are combinational. The hit flag, the hit index and a one-cycle "mapping changed" pulse all leave through a register stage. Logic that mirrors the header can use the pulse to learn that the set of decoded windows has moved, with no need to compare the registers itself. Translation into a host address space and the bus protocol around a transaction are handled outside this block.

Top module: `barDecoder`

## Requirements
- R1: A region whose type bit is 1 (I/O space) can be mapped only while command bit 0 (`cmdBits[0]`) is 1.
- R2: A region whose type bit is 0 (memory space) can be mapped only while command bit 1 (`cmdBits[1]`) is 1.
- R3: Region 6 is the ROM slot. It is always memory space, and it is mapped only when bit 0 of its own base register value is also 1.
- R4: The window base is the register value ANDed with the inverse of (size − 1). The last address is base + size − 1. An address hits when base ≤ address ≤ last, both bounds inclusive.
- R5: A window whose base is zero, or whose last address is not greater than its base, is unmapped.
- R6: An I/O window whose last address is 0x10000 or higher is unmapped.
- R7: A hit also requires the transaction space to match the region space: `txnIsIo` must equal `ioType[i]` for regions 0 to 5, and must be 0 for the ROM slot.
- R8: When several windows match, the lowest region index is reported.
- R9: When no window matches, `hitValid` is 0 and `hitIdx` is 0.
- R10: `hitValid`, `hitIdx` and `mapChanged` are registered. They show the result for the inputs present at the previous rising clock edge and do not change between edges.
- R11: After an edge where the set of mapped flags, or the base of any mapped region, differs from that of the edge before, `mapChanged` is 1 for that cycle. Other input changes do not raise it. These include masked-off low bits of a base and writes to an unmapped region.
- R12: While reset is asserted, every output is 0 and the stored mapping history reads as "all regions unmapped".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| barVals | input | 7 x ADDR_W | Current base register value per region; index 6 is the ROM slot |
| regionSizes | input | 7 x ADDR_W | Size in bytes of each region |
| ioType | input | 6 | Space type per general region, 1 = I/O, 0 = memory |
| cmdBits | input | 2 | Bit 0 enables I/O space, bit 1 enables memory space |
| txnAddr | input | ADDR_W | Address of the incoming transaction |
| txnIsIo | input | 1 | 1 for an I/O transaction, 0 for a memory transaction |
| hitValid | output | 1 | A mapped window claimed the transaction |
| hitIdx | output | 3 | Index of the claiming region, 0 when there is no hit |
| mapChanged | output | 1 | One-cycle pulse when the decoded windows moved |

## Verification
A window update and a transaction lookup can land in the same cycle. The hit result must then be judged against the new windows, and `mapChanged` must pulse alongside it. The bench provokes this by changing the command bits, the ROM enable bit or a base register together with the first probe address of each sweep. The expected hit and the expected pulse are both worked out from the freshly applied configuration and the one applied before it. The sweep probes just below, at, and just past each window edge in both spaces. Overlapping windows show the priority rule. A second configuration holds a zero base, a one-byte window, an I/O window past the port limit, and a disabled ROM.

// File: rtl/barDecodePkg.sv
package barDecodePkg;
  localparam int REGION_COUNT = 7;
  localparam int BAR_COUNT    = REGION_COUNT - 1;
  localparam int ROM_SLOT     = REGION_COUNT - 1;
  localparam int IDX_W        = $clog2(REGION_COUNT);

  // Strobes from the window datapath to the hit control.
  typedef struct packed {
    logic [REGION_COUNT-1:0] regionHit;
    logic                    windowMoved;
  } pathStrobe_t;
endpackage

// File: rtl/barWindowUnit.sv
module barWindowUnit #(
  parameter int          ADDR_W   = 32,
  parameter bit          IS_ROM   = 1'b0,
  parameter int unsigned IO_LIMIT = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] barVal,
  input  logic [ADDR_W-1:0] sizeVal,
  input  logic              isIo,
  input  logic              ioEn,
  input  logic              memEn,
  output logic              mapped,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] lastAddr
);
  localparam logic [ADDR_W:0] IO_LIM_W = (ADDR_W+1)'(IO_LIMIT);

  logic romOn;
  logic spaceOn;
  logic ioOk;

  generate
    if (IS_ROM) begin : g_rom
      assign romOn = barVal[0];
    end else begin : g_bar
      assign romOn = 1'b1;
    end
  endgenerate

  always_comb begin
    baseAddr = barVal & ~(sizeVal - ADDR_W'(1));
    lastAddr = baseAddr + sizeVal - ADDR_W'(1);
    spaceOn  = isIo ? ioEn : memEn;
    ioOk     = !isIo || ({1'b0, lastAddr} < IO_LIM_W);
    mapped   = spaceOn && romOn && (baseAddr != '0) &&
               (lastAddr > baseAddr) && ioOk;
  end
endmodule

// File: rtl/barWindowPath.sv
module barWindowPath
  import barDecodePkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int unsigned IO_LIMIT = 32'h0001_0000
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [REGION_COUNT-1:0][ADDR_W-1:0] barVals,
  input  logic [REGION_COUNT-1:0][ADDR_W-1:0] regionSizes,
  input  logic [BAR_COUNT-1:0]                ioType,
  input  logic [1:0]                          cmdBits,
  input  logic [ADDR_W-1:0]                   txnAddr,
  input  logic                                txnIsIo,
  output pathStrobe_t                         strobes
);
  logic [REGION_COUNT-1:0]             regIo;
  logic [REGION_COUNT-1:0]             regMapped;
  logic [REGION_COUNT-1:0][ADDR_W-1:0] regBase;
  logic [REGION_COUNT-1:0][ADDR_W-1:0] regLast;
  logic [REGION_COUNT-1:0][ADDR_W:0]   curDesc;
  logic [REGION_COUNT-1:0][ADDR_W:0]   prevDesc;

  generate
    for (genvar i = 0; i < REGION_COUNT; i++) begin : g_region
      if (i == ROM_SLOT) begin : g_romType
        assign regIo[i] = 1'b0;
      end else begin : g_barType
        assign regIo[i] = ioType[i];
      end

      barWindowUnit #(
        .ADDR_W  (ADDR_W),
        .IS_ROM  (i == ROM_SLOT),
        .IO_LIMIT(IO_LIMIT)
      ) uWin (
        .barVal  (barVals[i]),
        .sizeVal (regionSizes[i]),
        .isIo    (regIo[i]),
        .ioEn    (cmdBits[0]),
        .memEn   (cmdBits[1]),
        .mapped  (regMapped[i]),
        .baseAddr(regBase[i]),
        .lastAddr(regLast[i])
      );

      assign strobes.regionHit[i] = regMapped[i] && (regIo[i] == txnIsIo) &&
                                    (txnAddr >= regBase[i]) && (txnAddr <= regLast[i]);
      assign curDesc[i] = {regMapped[i], regMapped[i] ? regBase[i] : '0};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevDesc <= '0;
    else       prevDesc <= curDesc;
  end

  assign strobes.windowMoved = (curDesc != prevDesc);
endmodule

// File: rtl/barHitCtrl.sv
module barHitCtrl
  import barDecodePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pathStrobe_t      strobes,
  output logic             hitValid,
  output logic [IDX_W-1:0] hitIdx,
  output logic             mapChanged
);
  logic             anyHit;
  logic [IDX_W-1:0] pickIdx;

  always_comb begin
    anyHit  = |strobes.regionHit;
    pickIdx = '0;
    for (int i = REGION_COUNT - 1; i >= 0; i--) begin
      if (strobes.regionHit[i]) pickIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid   <= 1'b0;
      hitIdx     <= '0;
      mapChanged <= 1'b0;
    end else begin
      hitValid   <= anyHit;
      hitIdx     <= pickIdx;
      mapChanged <= strobes.windowMoved;
    end
  end
endmodule

// File: rtl/barDecoder.sv
module barDecoder
  import barDecodePkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int unsigned IO_LIMIT = 32'h0001_0000
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [REGION_COUNT-1:0][ADDR_W-1:0] barVals,
  input  logic [REGION_COUNT-1:0][ADDR_W-1:0] regionSizes,
  input  logic [BAR_COUNT-1:0]                ioType,
  input  logic [1:0]                          cmdBits,
  input  logic [ADDR_W-1:0]                   txnAddr,
  input  logic                                txnIsIo,
  output logic                                hitValid,
  output logic [IDX_W-1:0]                    hitIdx,
  output logic                                mapChanged
);
  pathStrobe_t strobes;

  barWindowPath #(.ADDR_W(ADDR_W), .IO_LIMIT(IO_LIMIT)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .barVals    (barVals),
    .regionSizes(regionSizes),
    .ioType     (ioType),
    .cmdBits    (cmdBits),
    .txnAddr    (txnAddr),
    .txnIsIo    (txnIsIo),
    .strobes    (strobes)
  );

  barHitCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hitValid  (hitValid),
    .hitIdx    (hitIdx),
    .mapChanged(mapChanged)
  );
endmodule

// File: rtl/barDecoderChk.sv
module barDecoderChk
  import barDecodePkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                                clk,
  input logic                                rstN,
  input logic [REGION_COUNT-1:0][ADDR_W-1:0] barVals,
  input logic [REGION_COUNT-1:0][ADDR_W-1:0] regionSizes,
  input logic [BAR_COUNT-1:0]                ioType,
  input logic [1:0]                          cmdBits,
  input logic                                txnIsIo,
  input logic                                hitValid,
  input logic [IDX_W-1:0]                    hitIdx,
  input logic                                mapChanged
);
  localparam int CFG_W = 2 * REGION_COUNT * ADDR_W + BAR_COUNT + 2;

  logic [CFG_W-1:0]     cfgNow;
  logic [CFG_W-1:0]     cfgQ;
  logic [CFG_W-1:0]     cfgQQ;
  logic [BAR_COUNT-1:0] ioTypeQ;
  logic [1:0]           cmdQ;
  logic                 txnIsIoQ;
  logic                 romEnQ;
  logic [1:0]           upCnt;

  assign cfgNow = {barVals, regionSizes, ioType, cmdBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt <= '0;
    end else if (upCnt != 2'd3) begin
      upCnt <= upCnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    cfgQ     <= cfgNow;
    cfgQQ    <= cfgQ;
    ioTypeQ  <= ioType;
    cmdQ     <= cmdBits;
    txnIsIoQ <= txnIsIo;
    romEnQ   <= barVals[ROM_SLOT][0];
  end

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitIdx == '0));

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    hitIdx < IDX_W'(REGION_COUNT));

  assert_space_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && hitValid && hitIdx != IDX_W'(ROM_SLOT)) |-> (ioTypeQ[hitIdx] == txnIsIoQ));

  assert_rom_rules_R3: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && hitValid && hitIdx == IDX_W'(ROM_SLOT)) |-> (!txnIsIoQ && romEnQ));

  assert_io_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && hitValid && txnIsIoQ) |-> cmdQ[0]);

  assert_mem_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && hitValid && !txnIsIoQ) |-> cmdQ[1]);

  assert_quiet_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2 && cfgQ == cfgQQ) |-> !mapChanged);

  assert_reset_clear_R12: assert property (@(posedge clk)
    !rstN |=> (!hitValid && !mapChanged && hitIdx == '0));
endmodule

bind barDecoder barDecoderChk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_barDecoder.sv
module sim_barDecoder;
  import barDecodePkg::*;

  localparam int AW = 32;
  localparam int DW = AW + 1;

  logic                            clk = 1'b0;
  logic                            rstN = 1'b0;
  logic [REGION_COUNT-1:0][AW-1:0] bv = '0;
  logic [REGION_COUNT-1:0][AW-1:0] sz = '0;
  logic [BAR_COUNT-1:0]            io = '0;
  logic [1:0]                      cmd = '0;
  logic [AW-1:0]                   addr = '0;
  logic                            isIo = 1'b0;
  logic                            hitValid;
  logic [IDX_W-1:0]                hitIdx;
  logic                            mapChanged;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [REGION_COUNT*DW-1:0] prevDesc = '0;
  int expHitPrev = 0;
  int expIdxPrev = 0;

  always #10 clk = ~clk;

  barDecoder u0 (
    .clk(clk), .rstN(rstN), .barVals(bv), .regionSizes(sz), .ioType(io),
    .cmdBits(cmd), .txnAddr(addr), .txnIsIo(isIo),
    .hitValid(hitValid), .hitIdx(hitIdx), .mapChanged(mapChanged)
  );

  function automatic bit regIsIo(input int i);
    if (i == ROM_SLOT) return 1'b0;
    return io[i];
  endfunction

  function automatic void winOf(input int i, output bit m, output logic [AW-1:0] b,
                                output logic [AW-1:0] l);
    bit rio;
    rio = regIsIo(i);
    b = bv[i] & ~(sz[i] - 32'd1);
    l = b + sz[i] - 32'd1;
    m = rio ? cmd[0] : cmd[1];
    if (i == ROM_SLOT && !bv[i][0]) m = 1'b0;
    if (b == 0 || l <= b) m = 1'b0;
    if (rio && l >= 32'h0001_0000) m = 1'b0;
  endfunction

  function automatic logic [REGION_COUNT*DW-1:0] descOf();
    logic [REGION_COUNT*DW-1:0] d;
    bit m;
    logic [AW-1:0] b, l;
    d = '0;
    for (int i = 0; i < REGION_COUNT; i++) begin
      winOf(i, m, b, l);
      d[i*DW +: DW] = {m, m ? b : 32'd0};
    end
    return d;
  endfunction

  function automatic void expectHit(output int h, output int idx);
    bit m;
    logic [AW-1:0] b, l;
    h = 0;
    idx = 0;
    for (int i = REGION_COUNT - 1; i >= 0; i--) begin
      winOf(i, m, b, l);
      if (m && regIsIo(i) == isIo && addr >= b && addr <= l) begin
        h = 1;
        idx = i;
      end
    end
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h addr=%0h io=%0d cmd=%0d",
               tag, act, exp, addr, isIo, cmd);
    end
  endtask

  // Called at a falling edge, just after the inputs have been set.
  task automatic apply(input string tag);
    int h, idx, chg;
    logic [REGION_COUNT*DW-1:0] nd;
    #1;
    chk("R10 hold hitValid", int'(hitValid), expHitPrev);
    chk("R10 hold hitIdx", int'(hitIdx), expIdxPrev);
    expectHit(h, idx);
    nd = descOf();
    chg = (nd != prevDesc) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " hitValid"}, int'(hitValid), h);
    chk({tag, " hitIdx"}, int'(hitIdx), idx);
    chk("R11 mapChanged", int'(mapChanged), chg);
    prevDesc = nd;
    expHitPrev = h;
    expIdxPrev = idx;
  endtask

  task automatic sweep(input string tag);
    logic [AW-1:0] rb, rl;
    logic [AW-1:0] pts[4];
    for (int i = 0; i < REGION_COUNT; i++) begin
      rb = bv[i] & ~(sz[i] - 32'd1);
      rl = rb + sz[i] - 32'd1;
      pts[0] = rb - 32'd1;
      pts[1] = rb;
      pts[2] = rl;
      pts[3] = rl + 32'd1;
      for (int p = 0; p < 4; p++) begin
        for (int s = 0; s < 2; s++) begin
          addr = pts[p];
          isIo = s[0];
          apply(tag);
        end
      end
    end
  endtask

  task automatic loadConfigA(input bit romEn);
    bv[0] = 32'h0000_1000; sz[0] = 32'h0000_0100;
    bv[1] = 32'h8000_0000; sz[1] = 32'h0000_1000;
    bv[2] = 32'h8000_0800; sz[2] = 32'h0000_0800;
    bv[3] = 32'h0000_1080; sz[3] = 32'h0000_0040;
    bv[4] = 32'h9000_0123; sz[4] = 32'h0001_0000;
    bv[5] = 32'h0000_2000; sz[5] = 32'h0000_0010;
    bv[6] = 32'hA000_0000 | {31'd0, romEn}; sz[6] = 32'h0002_0000;
    io    = 6'b101001;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset hitValid", int'(hitValid), 0);
    chk("R12 reset hitIdx", int'(hitIdx), 0);
    chk("R12 reset mapChanged", int'(mapChanged), 0);
    rstN = 1'b1;

    // Enables, ROM bit, masking, inclusive bounds, space match, priority.
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 2; r++) begin
        loadConfigA(r[0]);
        cmd = c[1:0];
        sweep("R1 R2 R3 R4 R7 R8 R9");
      end
    end

    // Invalid windows: zero base, one-byte window, I/O past the port limit,
    // disabled ROM, and a memory window reaching the top address.
    cmd = 2'b11;
    bv[0] = 32'h0001_0000; sz[0] = 32'h0000_0004;
    bv[1] = 32'h0000_4000; sz[1] = 32'h0000_0001;
    bv[2] = 32'h7FFF_FFF0; sz[2] = 32'h0000_0010;
    bv[3] = 32'h0000_FF00; sz[3] = 32'h0000_0100;
    bv[4] = 32'h8000_0000; sz[4] = 32'h8000_0000;
    bv[5] = 32'h0000_0000; sz[5] = 32'h0000_0010;
    bv[6] = 32'hB000_0000; sz[6] = 32'h0000_1000;
    io    = 6'b101001;
    sweep("R5 R6 R3 R4");

    // Change pulse behaviour.
    loadConfigA(1'b1);
    cmd = 2'b11;
    addr = 32'h9000_0010; isIo = 1'b0;
    apply("R11 load");
    apply("R11 steady");
    bv[4] = 32'h9000_0456;
    apply("R11 masked bits");
    cmd = 2'b10;
    apply("R11 io off");
    bv[0] = 32'h0000_3000;
    apply("R11 unmapped write");
    bv[1] = 32'h8000_1000;
    addr = 32'h8000_1000;
    apply("R11 base moved");
    apply("R11 settle");

    // Reset in mid-run clears history.
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R12 midrun hitValid", int'(hitValid), 0);
    chk("R12 midrun mapChanged", int'(mapChanged), 0);
    rstN = 1'b1;
    prevDesc = '0;
    expHitPrev = 0;
    expIdxPrev = 0;
    apply("R12 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule